// File: doc/BRIEF.md
# Integrate-and-Dump Bit Synchroniser with Preamble Lock

This block sits behind a carrier-recovery loop and turns a stream of signed, demodulated in-phase samples into bits. An integrator sums the samples over each bit period and clears itself at the start of the next one, so its output rises or falls as a ramp that peaks at the end of the bit. A three-sample window over the integrator output looks for that peak using comparisons only. Each peak yields one hard bit taken from the sign of the integrator.

Before any bit is released, the recovered bits slide through a history register that is compared with a preamble pattern held as a parameter. The pattern and its complement are both accepted. A complement match marks the stream as phase-inverted, which resolves the 180-degree ambiguity of binary phase keying, and every later bit is corrected for it. Lock is lost when peaks stop arriving, and the search then starts again. The samples per bit, the peak threshold and the preamble are parameters. At the nominal 1 Mbit/s bit rate, one sample strobe arrives every 1/SPB microsecond.

Top module: `intdump_bitsync`

## Requirements
- R1: The integrator counts accepted sample strobes from reset. The first strobe of every group of SPB strobes starts a new sum, and each later strobe in the group adds to it, so at the end of a bit the sum is exactly SPB times a constant sample value.
- R2: A peak is declared for a window sample when the middle (present) integrator value has a magnitude at least that of the one before it (early) and the one after it (late). Peak_o is a one-cycle pulse, and a stream of constant-amplitude bits gives exactly one pulse per bit.
- R3: The present magnitude must be strictly greater than THRESH. With SPB = 8 and THRESH = 400, an amplitude of 50 gives no peak and an amplitude of 51 gives one peak per bit.
- R4: The bit is 1 when the integrator is positive at the peak and 0 otherwise, XORed with the polarity flag.
- R5: Bit_vld_o pulses only while locked, once per peak, together with peak_o. Bits received before and including the last preamble bit are not released.
- R6: On each peak while unlocked, the history register shifts left and the new bit enters at bit 0, so the oldest bit sits at the MSB. Lock is raised when the history equals PRE_PAT, with pol_inv_o = 0, or when it equals ~PRE_PAT, with pol_inv_o = 1. Lock_o rises in the same cycle as that peak_o pulse.
- R7: While locked, 2*SPB consecutive window samples without a peak drop lock_o. On loss, pol_inv_o returns to 0 and the history register is cleared.
- R8: After reset, peak_o, bit_o, bit_vld_o, lock_o and pol_inv_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | SMP_W | Signed demodulated in-phase sample |
| bit_o | output | 1 | Recovered bit, polarity corrected |
| bit_vld_o | output | 1 | One-cycle strobe for bit_o |
| peak_o | output | 1 | One-cycle pulse at each detected peak |
| lock_o | output | 1 | Preamble found and peaks still arriving |
| pol_inv_o | output | 1 | Preamble was received inverted |

## Verification
The integrator registers a strobe at the clock edge that accepts it, and the window shifts one edge later. The outputs are registered one edge after that, so peak_o, bit_o, bit_vld_o and a change of lock_o all appear two cycles after the strobe that supplies the late sample, which is the first sample of the following bit. The bench drives and samples on falling edges and counts pulses as they happen. It compares counts and bit sequences only after at least five idle cycles. The lock-loss boundary is probed by feeding exactly 2*SPB trailing zero samples, which must leave lock_o high, and then one more, which must drop it.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
   typedef enum logic {
      POL_NORMAL   = 1'b0,
      POL_INVERTED = 1'b1
   } pol_e;

   typedef enum logic {
      ST_SEARCH = 1'b0,
      ST_LOCKED = 1'b1
   } lock_state_e;
endpackage

// File: rtl/bs_integrator.sv
module bs_integrator #(
   parameter int SMP_W = 12,
   parameter int SPB   = 8,
   parameter int ACC_W = SMP_W + $clog2(SPB)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic signed [SMP_W-1:0] smp_i,
   output logic signed [ACC_W-1:0] acc_o,
   output logic                    acc_vld_o
);
   localparam int PH_W = $clog2(SPB);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(SPB - 1);

   generate
      if (SPB < 3) begin : g_bad_spb
         $error("bs_integrator: SPB must be at least 3");
      end
      if (ACC_W < SMP_W + $clog2(SPB)) begin : g_bad_accw
         $error("bs_integrator: ACC_W too narrow for SPB samples");
      end
   endgenerate

   logic [PH_W-1:0]         phase;
   logic signed [ACC_W-1:0] smp_ext;

   assign smp_ext = {{(ACC_W - SMP_W){smp_i[SMP_W-1]}}, smp_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= '0;
         acc_o     <= '0;
         acc_vld_o <= 1'b0;
      end else begin
         acc_vld_o <= vld_i;
         if (vld_i) begin
            if (phase == '0) acc_o <= smp_ext;
            else             acc_o <= acc_o + smp_ext;
            if (phase == PH_LAST) phase <= '0;
            else                  phase <= phase + 1'b1;
         end
      end
   end

   // R1: the first strobe of a bit period replaces the running sum
   p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && phase == '0) |=> (acc_o == $past(smp_ext)));

   // R1: the period closes after exactly SPB strobes
   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && phase == PH_LAST) |=> (phase == '0));
endmodule

// File: rtl/bs_peak_window.sv
module bs_peak_window #(
   parameter int ACC_W  = 15,
   parameter int THRESH = 400
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [ACC_W-1:0] acc_i,
   input  logic                    acc_vld_i,
   output logic                    win_vld_o,
   output logic                    peak_o,
   output logic                    raw_bit_o
);
   localparam int MAG_W = ACC_W + 1;
   localparam logic [MAG_W-1:0] THR = MAG_W'(THRESH);

   generate
      if (THRESH < 0 || THRESH >= (2 ** (ACC_W - 1))) begin : g_bad_thr
         $error("bs_peak_window: THRESH outside the integrator range");
      end
   endgenerate

   logic signed [ACC_W-1:0] early, pres, late;
   logic [MAG_W-1:0]        mag_e, mag_p, mag_l;

   function automatic logic [MAG_W-1:0] mag(input logic signed [ACC_W-1:0] x);
      logic signed [MAG_W-1:0] w;
      w = MAG_W'(x);
      return w[MAG_W-1] ? MAG_W'(-w) : MAG_W'(w);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         early     <= '0;
         pres      <= '0;
         late      <= '0;
         win_vld_o <= 1'b0;
      end else begin
         win_vld_o <= acc_vld_i;
         if (acc_vld_i) begin
            late  <= acc_i;
            pres  <= late;
            early <= pres;
         end
      end
   end

   always_comb begin
      mag_e     = mag(early);
      mag_p     = mag(pres);
      mag_l     = mag(late);
      peak_o    = win_vld_o && (mag_p >= mag_e) && (mag_p >= mag_l) && (mag_p > THR);
      raw_bit_o = !pres[ACC_W-1] && (pres != '0);
   end

   // R2: the window advances by one integrator value per strobe
   p_window_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld_i |=> (late == $past(acc_i)) && (pres == $past(late)));
endmodule

// File: rtl/bs_sync_lock.sv
module bs_sync_lock
   import bsync_pkg::*;
#(
   parameter int                  PRE_LEN   = 8,
   parameter logic [PRE_LEN-1:0]  PRE_PAT   = 8'hB2,
   parameter int                  SPB       = 8,
   parameter bit                  ALLOW_INV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic win_vld_i,
   input  logic peak_i,
   input  logic raw_i,
   output logic peak_o,
   output logic bit_o,
   output logic bit_vld_o,
   output logic lock_o,
   output logic pol_inv_o
);
   localparam int LOSS  = 2 * SPB;
   localparam int GAP_W = $clog2(LOSS + 1);
   localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(LOSS - 1);

   generate
      if (PRE_LEN < 2) begin : g_bad_len
         $error("bs_sync_lock: PRE_LEN must be at least 2");
      end
   endgenerate

   lock_state_e          state;
   pol_e                 pol;
   logic [PRE_LEN-1:0]   hist;
   logic [PRE_LEN-1:0]   cand;
   logic [GAP_W-1:0]     gap;
   logic                 hit_norm, hit_inv;

   assign cand     = {hist[PRE_LEN-2:0], raw_i};
   assign hit_norm = (cand == PRE_PAT);

   generate
      if (ALLOW_INV) begin : g_inv_match
         assign hit_inv = (cand == ~PRE_PAT);
      end else begin : g_norm_only
         assign hit_inv = 1'b0;
      end
   endgenerate

   assign lock_o    = (state == ST_LOCKED);
   assign pol_inv_o = (pol == POL_INVERTED);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_SEARCH;
         pol       <= POL_NORMAL;
         hist      <= '0;
         gap       <= '0;
         peak_o    <= 1'b0;
         bit_o     <= 1'b0;
         bit_vld_o <= 1'b0;
      end else begin
         peak_o    <= peak_i;
         bit_vld_o <= 1'b0;
         if (state == ST_LOCKED) begin
            if (peak_i) begin
               bit_o     <= raw_i ^ (pol == POL_INVERTED);
               bit_vld_o <= 1'b1;
               gap       <= '0;
            end else if (win_vld_i) begin
               if (gap == GAP_LAST) begin
                  state <= ST_SEARCH;
                  pol   <= POL_NORMAL;
                  hist  <= '0;
                  gap   <= '0;
               end else begin
                  gap <= gap + 1'b1;
               end
            end
         end else if (peak_i) begin
            hist <= cand;
            gap  <= '0;
            if (hit_norm) begin
               state <= ST_LOCKED;
               pol   <= POL_NORMAL;
            end else if (hit_inv) begin
               state <= ST_LOCKED;
               pol   <= POL_INVERTED;
            end
         end
      end
   end

   // R4: every released bit coincides with a peak pulse
   p_bit_on_peak_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld_o |-> peak_o);

   // R5: bits leave only while locked
   p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld_o |-> lock_o);

   // R6: lock is gained only on a peak
   p_lock_on_peak_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> peak_o);

   // R7: lock is lost only after a peak-free stretch
   p_loss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_o) |-> (!peak_o && !pol_inv_o));
endmodule

// File: rtl/intdump_bitsync.sv
module intdump_bitsync #(
   parameter int                  SMP_W     = 12,
   parameter int                  SPB       = 8,
   parameter int                  THRESH    = 400,
   parameter int                  PRE_LEN   = 8,
   parameter logic [PRE_LEN-1:0]  PRE_PAT   = 8'hB2,
   parameter bit                  ALLOW_INV = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_vld_i,
   input  logic signed [SMP_W-1:0] smp_i,
   output logic                    bit_o,
   output logic                    bit_vld_o,
   output logic                    peak_o,
   output logic                    lock_o,
   output logic                    pol_inv_o
);
   localparam int ACC_W = SMP_W + $clog2(SPB);

   generate
      if (SMP_W < 2) begin : g_bad_smpw
         $error("intdump_bitsync: SMP_W must be at least 2");
      end
   endgenerate

   logic signed [ACC_W-1:0] acc;
   logic                    acc_vld;
   logic                    win_vld, peak_now, raw_bit;

   bs_integrator #(.SMP_W(SMP_W), .SPB(SPB), .ACC_W(ACC_W)) u_int (
      .clk(clk), .rst_n(rst_n), .vld_i(smp_vld_i), .smp_i(smp_i),
      .acc_o(acc), .acc_vld_o(acc_vld)
   );

   bs_peak_window #(.ACC_W(ACC_W), .THRESH(THRESH)) u_win (
      .clk(clk), .rst_n(rst_n), .acc_i(acc), .acc_vld_i(acc_vld),
      .win_vld_o(win_vld), .peak_o(peak_now), .raw_bit_o(raw_bit)
   );

   bs_sync_lock #(.PRE_LEN(PRE_LEN), .PRE_PAT(PRE_PAT), .SPB(SPB),
                  .ALLOW_INV(ALLOW_INV)) u_lock (
      .clk(clk), .rst_n(rst_n), .win_vld_i(win_vld), .peak_i(peak_now),
      .raw_i(raw_bit), .peak_o(peak_o), .bit_o(bit_o), .bit_vld_o(bit_vld_o),
      .lock_o(lock_o), .pol_inv_o(pol_inv_o)
   );
endmodule

// File: tb/sim_intdump_bitsync.sv
`timescale 1ns/1ps
module sim_intdump_bitsync;
   localparam int SMP_W = 12;
   localparam int SPB = 8;
   localparam int THRESH = 400;
   localparam int PRE_LEN = 8;
   localparam logic [PRE_LEN-1:0] PRE_PAT = 8'hB2;
   localparam int ND = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vld = 1'b0;
   logic signed [SMP_W-1:0] smp = '0;
   logic bit_o, bit_vld, peak, lock, pol_inv;

   int nchk = 0, nfail = 0, npk = 0, ngot = 0;
   bit done = 1'b0;
   bit got [0:63];
   bit data [0:63];

   always #2.5 clk = ~clk;

   intdump_bitsync #(.SMP_W(SMP_W), .SPB(SPB), .THRESH(THRESH),
                     .PRE_LEN(PRE_LEN), .PRE_PAT(PRE_PAT), .ALLOW_INV(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld_i(vld), .smp_i(smp),
      .bit_o(bit_o), .bit_vld_o(bit_vld), .peak_o(peak), .lock_o(lock),
      .pol_inv_o(pol_inv)
   );

   always @(negedge clk) begin
      if (rst_n && peak) npk++;
      if (rst_n && bit_vld && ngot < 64) begin
         got[ngot] = bit_o;
         ngot++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic put(input int v);
      @(negedge clk);
      vld = 1'b1;
      smp = v[SMP_W-1:0];
      @(negedge clk);
      vld = 1'b0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
   endtask

   task automatic send_bit(input bit b, input int amp);
      for (int k = 0; k < SPB; k++) put(b ? amp : -amp);
   endtask

   task automatic zeros(input int n);
      for (int k = 0; k < n; k++) put(0);
   endtask

   task automatic drain();
      repeat (6) @(negedge clk);
   endtask

   task automatic lock_run(input bit inv, input string tag);
      npk = 0;
      ngot = 0;
      for (int i = 0; i < 8; i++) send_bit(1'b0, 100);
      for (int i = PRE_LEN - 1; i >= 0; i--) send_bit(PRE_PAT[i] ^ inv, $urandom_range(60, 200));
      for (int i = 0; i < ND; i++) begin
         data[i] = 1'($urandom_range(0, 1));
         send_bit(data[i] ^ inv, $urandom_range(60, 200));
      end
      zeros(2 * SPB);
      drain();
      chk(npk == 8 + PRE_LEN + ND, {tag, " R2 one peak per bit"}, npk, 8 + PRE_LEN + ND);
      chk(npk == 8 + PRE_LEN + ND, {tag, " R1 aligned dump periods"}, npk, 8 + PRE_LEN + ND);
      chk(lock == 1'b1, {tag, " R6 lock after preamble"}, lock, 1);
      chk(pol_inv == inv, {tag, " R6 polarity flag"}, pol_inv, inv);
      chk(ngot == ND, {tag, " R5 only post-preamble bits released"}, ngot, ND);
      for (int i = 0; i < ND; i++)
         chk(got[i] == data[i], {tag, " R4 recovered bit"}, got[i], data[i]);
      chk(lock == 1'b1, {tag, " R7 lock held after 2*SPB-1 quiet samples"}, lock, 1);
      zeros(1);
      drain();
      chk(lock == 1'b0, {tag, " R7 lock dropped after 2*SPB quiet samples"}, lock, 0);
      chk(pol_inv == 1'b0, {tag, " R7 polarity cleared on loss"}, pol_inv, 0);
      zeros(SPB - 1);
      drain();
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      chk(peak == 1'b0, "R8 reset peak", peak, 0);
      chk(bit_o == 1'b0, "R8 reset bit", bit_o, 0);
      chk(bit_vld == 1'b0, "R8 reset bit_vld", bit_vld, 0);
      chk(lock == 1'b0, "R8 reset lock", lock, 0);
      chk(pol_inv == 1'b0, "R8 reset polarity", pol_inv, 0);
      rst_n = 1'b1;
      drain();

      // threshold boundary: SPB*50 = THRESH gives nothing, SPB*51 passes
      npk = 0;
      for (int i = 0; i < 10; i++) send_bit(1'(i % 2), 50);
      drain();
      chk(npk == 0, "R3 sum equal to threshold gives no peak", npk, 0);
      chk(npk == 0, "R1 exact sum of SPB samples", npk, 0);
      npk = 0;
      for (int i = 0; i < 10; i++) send_bit(1'(i % 2), 51);
      zeros(3 * SPB);
      drain();
      chk(npk == 10, "R3 sum above threshold peaks once per bit", npk, 10);
      chk(lock == 1'b0, "R6 no lock without preamble", lock, 0);
      chk(ngot == 0, "R5 no bits while unlocked", ngot, 0);

      lock_run(1'b0, "normal");
      lock_run(1'b1, "inverted");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   end
endmodule